// File: doc/BRIEF.md
# Rotational Position and Latency Tracker

This block follows the angular position of a head-per-track disk as a word-slot counter that never stops. A prescaler divides the clock by a programmable interword period. Each time that period expires, the slot position moves on by one, modulo the number of words on a track. From that position the block drives three signals. The first is an index window, which is high during the first few slots of every revolution. The second is an address-confirm flag, which the skip test uses when the target word is under the heads. The third is a word-slot tick, which paces transfers that move one word per period.

A transfer command raises `start_i` for one cycle and presents the low disk address on `target_i`. The block works out the rotational distance, in word slots, from the current angle to the target word. It counts that distance down on every slot step. When the count reaches zero it gives the transfer engine a single-cycle start strobe, at the moment the target word arrives. A new start during the wait throws the old target away and measures again from the new one. Track selection and data storage belong to the transfer engine, not to this block.

Top module: `rot_tracker`

## Requirements
- R1: `pos_o` counts modulo 2^POS_W (2048 by default). It moves up by exactly one on each slot step, goes from 2047 back to 0, and is 0 after reset.
- R2: With P = `period_i`, where a value of 0 is used as 1, a slot step happens on every P-th clock after reset. The first step comes on the P-th cycle. `slot_tick_o` is high in exactly the cycles whose closing edge advances the position.
- R3: `index_o` is high exactly while `pos_o` is below INDEX_SLOTS (6 by default).
- R4: `addr_match_o` is high exactly while `target_i` equals `pos_o`.
- R5: A start taken at a clock edge waits L = (target − position after that edge) mod 2048 slot steps. It then raises `start_strobe_o` for one cycle, and `pos_o` equals the target in that cycle. When L = 0, the strobe comes in the cycle right after the start.
- R6: A start that arrives while a wait is in progress drops the earlier target. Only the new target produces a strobe.
- R7: Reset sets the position to zero, cancels any pending start, and holds `busy_o` and `start_strobe_o` low.
- R8: `busy_o` is high from the cycle after a start up to and including the strobe cycle. It is low in the cycle after the strobe when no new start is given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| period_i | input | PER_W | Interword period in clock cycles (0 acts as 1) |
| target_i | input | POS_W | Low disk address (target word slot) |
| start_i | input | 1 | One-cycle command start request |
| pos_o | output | POS_W | Current angular word-slot position |
| index_o | output | 1 | Index (photocell) window |
| addr_match_o | output | 1 | Target word is under the heads |
| slot_tick_o | output | 1 | Slot step happens at the coming edge |
| start_strobe_o | output | 1 | Target word reached, begin transfer |
| busy_o | output | 1 | Latency wait in progress |

## Verification
The bench compares position, tick, index window and address confirm against the closed form floor(n/P) mod 2048 on every cycle. It does this for periods 0, 1 and 3, so the zero-as-one rule and a divide by more than one are both exercised, and one run covers several full revolutions, including the wrap. The latency function is tried with rotational distances spread across the whole track, including zero, one and the maximum of 2047. The bench counts the slot ticks seen before the strobe, which separates an off-by-one in the distance from an off-by-one in the prescaler phase. A restart with a nearer abandoned target shows whether the old wait is really dropped.

// File: rtl/rot_pkg.sv
package rot_pkg;
    typedef enum logic {
        LAT_IDLE = 1'b0,
        LAT_WAIT = 1'b1
    } lat_state_e;
endpackage

// File: rtl/rot_prescaler.sv
module rot_prescaler #(
    parameter int PER_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PER_W-1:0] period_i,
    output logic             step_o
);
    typedef struct packed {
        logic [PER_W-1:0] cnt;
    } pre_t;

    pre_t             s_d, s_q;
    logic [PER_W-1:0] eff_per;
    logic [PER_W-1:0] last_cnt;

    always_comb begin
        eff_per  = (period_i == '0) ? PER_W'(1) : period_i;
        last_cnt = eff_per - PER_W'(1);
        // a shortened period takes effect at once
        step_o   = (s_q.cnt >= last_cnt);
        s_d      = s_q;
        if (step_o) s_d.cnt = '0;
        else        s_d.cnt = s_q.cnt + PER_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R2: the phase count restarts right after each step
    a_r2_phase_restart: assert property (@(posedge clk) disable iff (!rst_n)
        step_o |=> (s_q.cnt == '0));

    // R2: without a step the phase count moves on by one
    a_r2_phase_advance: assert property (@(posedge clk) disable iff (!rst_n)
        !step_o |=> (s_q.cnt == $past(s_q.cnt) + PER_W'(1)));
endmodule

// File: rtl/rot_angle.sv
module rot_angle #(
    parameter int POS_W       = 11,
    parameter int INDEX_SLOTS = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_i,
    input  logic [POS_W-1:0] target_i,
    output logic [POS_W-1:0] pos_o,
    output logic [POS_W-1:0] pos_next_o,
    output logic             index_o,
    output logic             match_o
);
    localparam logic [POS_W-1:0] POS_MAX = {POS_W{1'b1}};

    typedef struct packed {
        logic [POS_W-1:0] pos;
    } ang_t;

    ang_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (step_i) s_d.pos = s_q.pos + POS_W'(1);
        pos_o      = s_q.pos;
        pos_next_o = s_d.pos;
        index_o    = (32'(s_q.pos) < INDEX_SLOTS);
        match_o    = (target_i == s_q.pos);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R1: the angle wraps from the last slot to zero
    a_r1_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && s_q.pos == POS_MAX) |=> (s_q.pos == '0));

    // R1: the angle holds between steps
    a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !step_i |=> $stable(s_q.pos));
endmodule

// File: rtl/rot_latency.sv
module rot_latency #(
    parameter int POS_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_i,
    input  logic             start_i,
    input  logic [POS_W-1:0] target_i,
    input  logic [POS_W-1:0] pos_i,
    input  logic [POS_W-1:0] pos_next_i,
    output logic             strobe_o,
    output logic             busy_o
);
    import rot_pkg::*;

    typedef struct packed {
        lat_state_e       st;
        logic [POS_W-1:0] lat;
        logic [POS_W-1:0] tgt;
    } lat_t;

    lat_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        busy_o   = (s_q.st == LAT_WAIT);
        strobe_o = busy_o && (s_q.lat == '0);
        if (start_i) begin
            // distance measured from the angle in effect after this edge
            s_d.st  = LAT_WAIT;
            s_d.lat = target_i - pos_next_i;
            s_d.tgt = target_i;
        end else if (strobe_o) begin
            s_d.st  = LAT_IDLE;
        end else if (busy_o && step_i) begin
            s_d.lat = s_q.lat - POS_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.st  <= LAT_IDLE;
            s_q.lat <= '0;
            s_q.tgt <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    // R5: the strobe lands on the latched target word
    a_r5_strobe_on_target: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_o |-> (pos_i == s_q.tgt));

    // R5: the strobe lasts a single cycle unless a new start is taken
    a_r5_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_o && !start_i) |=> !strobe_o);

    // R8: a taken start makes the block busy
    a_r8_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> busy_o);

    // R5: the remaining distance falls by one per slot step
    a_r5_count_down: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !start_i && step_i && s_q.lat != '0)
            |=> (s_q.lat == $past(s_q.lat) - POS_W'(1)));
endmodule

// File: rtl/rot_tracker.sv
module rot_tracker #(
    parameter int POS_W       = 11,
    parameter int PER_W       = 8,
    parameter int INDEX_SLOTS = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PER_W-1:0] period_i,
    input  logic [POS_W-1:0] target_i,
    input  logic             start_i,
    output logic [POS_W-1:0] pos_o,
    output logic             index_o,
    output logic             addr_match_o,
    output logic             slot_tick_o,
    output logic             start_strobe_o,
    output logic             busy_o
);
    logic             step;
    logic [POS_W-1:0] pos_next;

    rot_prescaler #(.PER_W(PER_W)) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .period_i (period_i),
        .step_o   (step)
    );

    rot_angle #(.POS_W(POS_W), .INDEX_SLOTS(INDEX_SLOTS)) u_ang (
        .clk        (clk),
        .rst_n      (rst_n),
        .step_i     (step),
        .target_i   (target_i),
        .pos_o      (pos_o),
        .pos_next_o (pos_next),
        .index_o    (index_o),
        .match_o    (addr_match_o)
    );

    rot_latency #(.POS_W(POS_W)) u_lat (
        .clk        (clk),
        .rst_n      (rst_n),
        .step_i     (step),
        .start_i    (start_i),
        .target_i   (target_i),
        .pos_i      (pos_o),
        .pos_next_i (pos_next),
        .strobe_o   (start_strobe_o),
        .busy_o     (busy_o)
    );

    assign slot_tick_o = step;

    // R3: the index window is only open at the start of a revolution
    a_r3_index_window: assert property (@(posedge clk) disable iff (!rst_n)
        index_o |-> (32'(pos_o) < INDEX_SLOTS));

    // R2: the angle only moves in a tick cycle
    a_r2_move_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (pos_o != $past(pos_o)) |-> $past(slot_tick_o));
endmodule

// File: tb/rot_tracker_tb.sv
module rot_tracker_tb;
    localparam int CLK_PERIOD = 10;
    localparam int POS_W      = 11;
    localparam int PER_W      = 8;
    localparam int SLOTS      = 1 << POS_W;
    localparam int IDX        = 6;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [PER_W-1:0] period_i = '0;
    logic [POS_W-1:0] target_i = '0;
    logic             start_i = 1'b0;
    logic [POS_W-1:0] pos_o;
    logic             index_o, addr_match_o, slot_tick_o, start_strobe_o, busy_o;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc_n   = 0;
    int peff    = 1;
    bit mon_en  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rot_tracker #(.POS_W(POS_W), .PER_W(PER_W), .INDEX_SLOTS(IDX)) u_dut (
        .clk(clk), .rst_n(rst_n), .period_i(period_i), .target_i(target_i),
        .start_i(start_i), .pos_o(pos_o), .index_o(index_o),
        .addr_match_o(addr_match_o), .slot_tick_o(slot_tick_o),
        .start_strobe_o(start_strobe_o), .busy_o(busy_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%0d exp=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    always @(posedge clk or negedge rst_n)
        if (!rst_n) cyc_n <= 0;
        else        cyc_n <= cyc_n + 1;

    // per-cycle closed-form check of angle, tick, index window and match
    always @(negedge clk) begin
        if (mon_en && rst_n) begin
            int ep;
            ep = (cyc_n / peff) % SLOTS;
            chk(int'(pos_o) == ep, "R1 position", int'(pos_o), ep);
            chk(slot_tick_o == ((cyc_n % peff) == peff - 1), "R2 tick",
                int'(slot_tick_o), int'((cyc_n % peff) == peff - 1));
            chk(index_o == (ep < IDX), "R3 index", int'(index_o), int'(ep < IDX));
            chk(addr_match_o == (int'(target_i) == ep), "R4 match",
                int'(addr_match_o), int'(int'(target_i) == ep));
        end
    end

    task automatic do_reset(input int p);
        @(negedge clk);
        mon_en   = 1'b0;
        rst_n    = 1'b0;
        start_i  = 1'b0;
        period_i = PER_W'(p);
        peff     = (p == 0) ? 1 : p;
        repeat (2) @(negedge clk);
        chk(pos_o == '0, "R7 reset pos", int'(pos_o), 0);
        chk(!busy_o, "R7 reset busy", int'(busy_o), 0);
        chk(!start_strobe_o, "R7 reset strobe", int'(start_strobe_o), 0);
        rst_n  = 1'b1;
        mon_en = 1'b1;
    endtask

    // called at a negedge; issues a start and measures the wait
    task automatic lat_run(input int t, input string req);
        int p1, lat, cyc, steps, idle_seen;
        p1  = (int'(pos_o) + int'(slot_tick_o)) % SLOTS;
        lat = (t - p1 + SLOTS) % SLOTS;
        target_i = POS_W'(t);
        start_i  = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        cyc = 1; steps = 0; idle_seen = 0;
        while (!start_strobe_o && cyc < 20000) begin
            if (!busy_o) idle_seen++;
            if (slot_tick_o) steps++;
            @(negedge clk);
            cyc++;
        end
        chk(start_strobe_o, {req, " strobe seen"}, int'(start_strobe_o), 1);
        chk(int'(pos_o) == t, {req, " strobe position"}, int'(pos_o), t);
        chk(steps == lat, {req, " slot steps waited"}, steps, lat);
        if (peff == 1) chk(cyc == lat + 1, {req, " cycles waited"}, cyc, lat + 1);
        chk(busy_o && idle_seen == 0, "R8 busy during wait", idle_seen, 0);
        @(negedge clk);
        chk(!start_strobe_o, "R5 strobe one cycle", int'(start_strobe_o), 0);
        chk(!busy_o, "R8 idle after strobe", int'(busy_o), 0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog: run hung act=0 exp=1");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int p0;
        // R1 R3: full revolution with wrap at period 1
        do_reset(1);
        repeat (SLOTS) @(negedge clk);
        chk(pos_o == '0, "R1 wrap after one revolution", int'(pos_o), 0);
        repeat (40) @(negedge clk);

        // R2: period sweep, including 0 used as 1
        for (int p = 0; p < 8; p++) begin
            do_reset(p);
            repeat (3 * IDX * ((p == 0) ? 1 : p) + 5) @(negedge clk);
        end

        // R5: distance sweep over the whole track at period 1
        do_reset(1);
        for (int d = 0; d < SLOTS; d += 89)
            lat_run((int'(pos_o) + d) % SLOTS, "R5");
        lat_run((int'(pos_o) + 1) % SLOTS, "R5");
        lat_run((int'(pos_o) + SLOTS - 1) % SLOTS, "R5");

        // R5 R2: slower period, phase-sensitive distances
        do_reset(3);
        repeat (4) @(negedge clk);
        lat_run(int'(pos_o), "R5");
        lat_run((int'(pos_o) + 1) % SLOTS, "R5");
        lat_run((int'(pos_o) + 5) % SLOTS, "R5");
        lat_run((int'(pos_o) + 300) % SLOTS, "R5");
        lat_run((int'(pos_o) + SLOTS - 1) % SLOTS, "R5");
        @(negedge clk);
        lat_run((int'(pos_o) + 2) % SLOTS, "R5");

        // R2: zero period behaves as one
        do_reset(0);
        lat_run(0, "R5");
        lat_run(100, "R5");

        // R6: restart drops a nearer earlier target
        do_reset(1);
        repeat (7) @(negedge clk);
        p0 = int'(pos_o);
        target_i = POS_W'((p0 + 60) % SLOTS);
        start_i  = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (10) begin
            chk(!start_strobe_o, "R6 no early strobe", int'(start_strobe_o), 0);
            @(negedge clk);
        end
        lat_run((p0 + 300) % SLOTS, "R6");

        // R7: reset during a wait cancels it
        target_i = POS_W'((int'(pos_o) + 500) % SLOTS);
        start_i  = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        do_reset(1);
        repeat (SLOTS + 10) begin
            chk(!start_strobe_o, "R7 cancelled wait", int'(start_strobe_o), 0);
            @(negedge clk);
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule